// File: doc/BRIEF.md
# Flash Access Session Arbiter

Several host clients share one quad SPI flash port. This block sits between them and that port. Each client sends a single command word. The word carries the client's identifier, an operation code and a 32-bit argument. The block keeps a session lock so that only one client can own the flash at a time. It also enforces the order of commands within a session: the session opens, a chip-select line is chosen, data operations run, and the session closes. Transfer sizes and erase sector sizes are checked before any flash work starts. Each command returns exactly one status word.

Commands that pass every check and need the flash go to a downstream flash engine through a start/done handshake. While the engine works, the block shows a busy flag. For read operations the response also carries the number of 32-bit words that will come back. Register reads are zero-padded to whole words. The block drives a 4-line active-low chip-select vector. At most one line is low, and only while a session is open.

Top module: `flash_session_arbiter`

## Requirements
- R1: Operation codes are 0 open, 1 close, 2 select, 3 read, 4 write, 5 erase, 6 register read, 7 register write. Status codes are 0 OK, 1 not owner/busy, 2 sequence error, 3 length or argument error, 4 configuring.
- R2: An open is granted (OK) only when no client owns the flash and `cfg_busy` is low. It returns code 1 when the flash is owned, by any client including the requester. It returns code 4 when the flash is free but configuration is in progress.
- R3: Every command other than open, from a client that is not the current owner or sent while nobody owns the flash, returns code 1 and changes nothing.
- R4: After each granted open, the owner must issue select before any read, write, erase or register command. Such a command issued before select returns code 2. The sequence check comes before the configuration and length checks.
- R5: A select whose argument is 0 to 3 drives `flash_cs_n` low on that one line only. An argument of 4 or more returns code 3 and leaves the lines unchanged.
- R6: Read and write lengths (the argument, in words) must be 1 to 1024. Any other length returns code 3.
- R7: A data command from a selected owner returns code 4 while `cfg_busy` is high. This check comes before the length check.
- R8: Erase accepts only sector sizes of 4, 32 or 64 (the argument, in KB). Any other value returns code 3.
- R9: Register read and register write byte counts must be 1 to 8, or code 3 is returned. An accepted register read reports ceil(count/4) words in `rsp_words`. An accepted read reports its length. All other responses report 0.
- R10: A close from the owner returns OK, releases the flash and raises all chip-select lines. While nobody owns the flash, all lines are high.
- R11: A close from a non-owner returns code 1 and leaves ownership and chip selects unchanged.
- R12: Only one command is outstanding at a time. `cmd_ready` is low from acceptance until the response is taken. `rsp_valid` and `rsp_status` hold until `rsp_ready` is seen.
- R13: A data command that passes all checks pulses `eng_start` for one cycle, one cycle after acceptance. It holds `flash_busy` high until `eng_done`, then responds OK. No other command starts the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_client | input | 2 | Identifier of the issuing client |
| cmd_op | input | 3 | Operation code |
| cmd_arg | input | 32 | Argument: length, chip-select index, sector size or byte count |
| cfg_busy | input | 1 | Device configuration in progress |
| rsp_valid | output | 1 | Status word available |
| rsp_ready | input | 1 | Host takes the status word |
| rsp_status | output | 3 | Status code |
| rsp_words | output | 11 | Number of data words the command returns |
| flash_cs_n | output | 4 | Active-low chip-select lines |
| flash_busy | output | 1 | Downstream engine is working on a command |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_done | input | 1 | Engine has finished |

## Verification
The assertions assume three things about the environment. A command's fields and `cfg_busy` stay stable from the cycle `cmd_valid` rises until acceptance. The engine raises `eng_done` only while `flash_busy` is high, and never in the same cycle as `eng_start`. `rsp_ready` is raised only after `rsp_valid` has been seen. The bench drives every input on the falling edge and holds each command until acceptance. Its engine model answers three cycles after it sees the start pulse. It changes `cfg_busy` only between commands, so every decision sees the level that was meant for it.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

    typedef enum logic [2:0] {
        OP_OPEN   = 3'd0,
        OP_CLOSE  = 3'd1,
        OP_SELECT = 3'd2,
        OP_READ   = 3'd3,
        OP_WRITE  = 3'd4,
        OP_ERASE  = 3'd5,
        OP_REG_RD = 3'd6,
        OP_REG_WR = 3'd7
    } fsa_op_e;

    typedef enum logic [2:0] {
        ST_OK        = 3'd0,
        ST_NOT_OWNER = 3'd1,
        ST_SEQ       = 3'd2,
        ST_LEN       = 3'd3,
        ST_CONFIG    = 3'd4
    } fsa_status_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ENGINE = 2'd1,
        S_RESP   = 2'd2
    } fsa_state_e;

    // Outcome of checking one command against the session state.
    typedef struct packed {
        fsa_status_e status;
        logic        grant;   // take ownership
        logic        rel;     // drop ownership
        logic        select;  // latch chip-select line
        logic        start;   // hand to flash engine
    } fsa_decision_t;

    function automatic logic is_data_op(input fsa_op_e op);
        return op inside {OP_READ, OP_WRITE, OP_ERASE, OP_REG_RD, OP_REG_WR};
    endfunction

    function automatic logic sector_ok(input logic [31:0] kb);
        return (kb == 32'd4) || (kb == 32'd32) || (kb == 32'd64);
    endfunction

endpackage

// File: rtl/fsa_cmd_check.sv
module fsa_cmd_check
    import fsa_pkg::*;
#(
    parameter int CLIENT_W       = 2,
    parameter int NUM_CS         = 4,
    parameter int MAX_XFER_WORDS = 1024,
    parameter int MAX_REG_BYTES  = 8,
    parameter int WORDS_W        = 11
) (
    input  logic [CLIENT_W-1:0] client,
    input  fsa_op_e             op,
    input  logic [31:0]         arg,
    input  logic                cfg_busy,
    input  logic                owned,
    input  logic [CLIENT_W-1:0] owner,
    input  logic                sel_done,
    output fsa_decision_t       dec,
    output logic [WORDS_W-1:0]  words
);

    logic len_ok;

    always_comb begin
        case (op)
            OP_READ, OP_WRITE:     len_ok = (arg != 32'd0) && (arg <= 32'(MAX_XFER_WORDS));
            OP_ERASE:              len_ok = sector_ok(arg);
            OP_REG_RD, OP_REG_WR:  len_ok = (arg != 32'd0) && (arg <= 32'(MAX_REG_BYTES));
            default:               len_ok = 1'b0;
        endcase
    end

    always_comb begin
        dec.status = ST_OK;
        dec.grant  = 1'b0;
        dec.rel    = 1'b0;
        dec.select = 1'b0;
        dec.start  = 1'b0;
        words      = '0;
        if (op == OP_OPEN) begin
            if (owned)         dec.status = ST_NOT_OWNER;
            else if (cfg_busy) dec.status = ST_CONFIG;
            else               dec.grant  = 1'b1;
        end else if (!owned || (client != owner)) begin
            dec.status = ST_NOT_OWNER;
        end else if (op == OP_CLOSE) begin
            dec.rel = 1'b1;
        end else if (op == OP_SELECT) begin
            if (arg >= 32'(NUM_CS)) dec.status = ST_LEN;
            else                    dec.select = 1'b1;
        end else if (is_data_op(op)) begin
            if (!sel_done)     dec.status = ST_SEQ;
            else if (cfg_busy) dec.status = ST_CONFIG;
            else if (!len_ok)  dec.status = ST_LEN;
            else begin
                dec.start = 1'b1;
                if (op == OP_READ)       words = WORDS_W'(arg);
                else if (op == OP_REG_RD) words = WORDS_W'((arg + 32'd3) >> 2);
            end
        end
    end

endmodule

// File: rtl/fsa_owner_lock.sv
module fsa_owner_lock #(
    parameter int CLIENT_W = 2,
    parameter int NUM_CS   = 4,
    parameter int CS_W     = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  logic                grant,
    input  logic                rel,
    input  logic                select,
    input  logic [CLIENT_W-1:0] client,
    input  logic [CS_W-1:0]     sel_idx,
    output logic                owned,
    output logic [CLIENT_W-1:0] owner,
    output logic                sel_done,
    output logic [NUM_CS-1:0]   cs_n
);

    logic [NUM_CS-1:0] cs_hit;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_hit[i] = (sel_idx == CS_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owned    <= 1'b0;
            owner    <= '0;
            sel_done <= 1'b0;
            cs_n     <= '1;
        end else if (accept) begin
            if (grant) begin
                owned    <= 1'b1;
                owner    <= client;
                sel_done <= 1'b0;
            end else if (rel) begin
                owned    <= 1'b0;
                sel_done <= 1'b0;
                cs_n     <= '1;
            end else if (select) begin
                sel_done <= 1'b1;
                cs_n     <= ~cs_hit;
            end
        end
    end

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n)) else $error("more than one chip select low"); // R5

    AST_CS_FREE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !owned |-> (&cs_n)) else $error("chip select low without owner"); // R10

    AST_OWNER_HELD: assert property (@(posedge clk) disable iff (rst)
        (owned && !(accept && rel)) |=> (owned && $stable(owner)))
        else $error("ownership moved without close"); // R3

endmodule

// File: rtl/flash_session_arbiter.sv
module flash_session_arbiter
    import fsa_pkg::*;
#(
    parameter int NUM_CLIENTS    = 4,
    parameter int NUM_CS         = 4,
    parameter int MAX_XFER_WORDS = 1024,
    parameter int MAX_REG_BYTES  = 8,
    localparam int CLIENT_W      = $clog2(NUM_CLIENTS),
    localparam int CS_W          = $clog2(NUM_CS),
    localparam int WORDS_W       = $clog2(MAX_XFER_WORDS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [CLIENT_W-1:0] cmd_client,
    input  logic [2:0]          cmd_op,
    input  logic [31:0]         cmd_arg,
    input  logic                cfg_busy,
    output logic                rsp_valid,
    input  logic                rsp_ready,
    output logic [2:0]          rsp_status,
    output logic [WORDS_W-1:0]  rsp_words,
    output logic [NUM_CS-1:0]   flash_cs_n,
    output logic                flash_busy,
    output logic                eng_start,
    input  logic                eng_done
);

    fsa_state_e         state;
    fsa_status_e        status_q;
    logic [WORDS_W-1:0] words_q;
    logic               start_q;
    fsa_decision_t      dec;
    logic [WORDS_W-1:0] words_d;
    logic               owned, sel_done, accept;
    logic [CLIENT_W-1:0] owner;

    assign cmd_ready = (state == S_IDLE);
    assign accept    = cmd_valid && cmd_ready;

    fsa_cmd_check #(
        .CLIENT_W(CLIENT_W), .NUM_CS(NUM_CS), .MAX_XFER_WORDS(MAX_XFER_WORDS),
        .MAX_REG_BYTES(MAX_REG_BYTES), .WORDS_W(WORDS_W)
    ) u_check (
        .client(cmd_client), .op(fsa_op_e'(cmd_op)), .arg(cmd_arg),
        .cfg_busy(cfg_busy), .owned(owned), .owner(owner), .sel_done(sel_done),
        .dec(dec), .words(words_d)
    );

    fsa_owner_lock #(.CLIENT_W(CLIENT_W), .NUM_CS(NUM_CS), .CS_W(CS_W)) u_lock (
        .clk(clk), .rst(rst), .accept(accept), .grant(dec.grant), .rel(dec.rel),
        .select(dec.select), .client(cmd_client), .sel_idx(cmd_arg[CS_W-1:0]),
        .owned(owned), .owner(owner), .sel_done(sel_done), .cs_n(flash_cs_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            status_q <= ST_OK;
            words_q  <= '0;
            start_q  <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (state)
                S_IDLE: if (accept) begin
                    status_q <= dec.status;
                    words_q  <= words_d;
                    if (dec.start) begin
                        state   <= S_ENGINE;
                        start_q <= 1'b1;
                    end else begin
                        state <= S_RESP;
                    end
                end
                S_ENGINE: if (eng_done) state <= S_RESP;
                S_RESP:   if (rsp_ready) state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    assign rsp_valid  = (state == S_RESP);
    assign rsp_status = status_q;
    assign rsp_words  = words_q;
    assign flash_busy = (state == S_ENGINE);
    assign eng_start  = start_q;

    AST_RSP_HELD: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) && !cmd_ready))
        else $error("response dropped before taken"); // R12

    AST_START_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> (owned && sel_done)) else $error("engine started without select"); // R4

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start) else $error("start longer than one cycle"); // R13

    AST_START_NOT_CONFIG: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> !$past(cfg_busy)) else $error("engine started while configuring"); // R7

endmodule

// File: tb/flash_session_arbiter_bench.sv
module flash_session_arbiter_bench;

    localparam int CW = 2;
    localparam int WW = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0, cmd_ready;
    logic [CW-1:0] cmd_client = '0;
    logic [2:0]  cmd_op = '0;
    logic [31:0] cmd_arg = '0;
    logic cfg_busy = 1'b0;
    logic rsp_valid, rsp_ready = 1'b0;
    logic [2:0] rsp_status;
    logic [WW-1:0] rsp_words;
    logic [3:0] flash_cs_n;
    logic flash_busy, eng_start;
    logic eng_done = 1'b0;

    always #10 clk = ~clk;

    flash_session_arbiter u_flash_session_arbiter (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_client(cmd_client), .cmd_op(cmd_op), .cmd_arg(cmd_arg), .cfg_busy(cfg_busy),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
        .rsp_words(rsp_words), .flash_cs_n(flash_cs_n), .flash_busy(flash_busy),
        .eng_start(eng_start), .eng_done(eng_done)
    );

    int checks = 0;
    int errors = 0;
    int start_cnt = 0;
    int eng_lat = 0;
    int cyc = 0;

    // engine model: finishes three cycles after the start pulse
    always @(negedge clk) begin
        eng_done <= 1'b0;
        if (eng_start) begin
            start_cnt = start_cnt + 1;
            eng_lat   = 3;
        end else if (eng_lat != 0) begin
            eng_lat = eng_lat - 1;
            if (eng_lat == 0) eng_done <= 1'b1;
        end
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // reference session state
    bit m_owned = 0;
    int m_owner = 0;
    bit m_sel = 0;
    int m_cs = 15;

    function automatic int model_status(int cl, int op, int arg, bit cfg);
        if (op == 0) return m_owned ? 1 : (cfg ? 4 : 0);
        if (!m_owned || cl != m_owner) return 1;
        if (op == 1) return 0;
        if (op == 2) return (arg >= 4) ? 3 : 0;
        if (!m_sel) return 2;
        if (cfg) return 4;
        if (op == 3 || op == 4) return (arg >= 1 && arg <= 1024) ? 0 : 3;
        if (op == 5) return (arg == 4 || arg == 32 || arg == 64) ? 0 : 3;
        return (arg >= 1 && arg <= 8) ? 0 : 3;
    endfunction

    task automatic do_cmd(input string tag, input int cl, input int op, input int arg,
                          input bit cfg, input int exp_given);
        int est, ewords, s0, busy_seen;
        bit eng;
        est    = model_status(cl, op, arg, cfg);
        eng    = (est == 0) && (op >= 3);
        ewords = !eng ? 0 : (op == 3) ? arg : (op == 6) ? (arg + 3) / 4 : 0;
        s0     = start_cnt;
        busy_seen = 0;
        @(negedge clk);
        cfg_busy   = cfg;
        cmd_valid  = 1'b1;
        cmd_client = CW'(cl);
        cmd_op     = 3'(op);
        cmd_arg    = 32'(arg);
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        check({tag, " R12 ready low after accept"}, int'(cmd_ready), 0);
        while (!rsp_valid) begin
            if (flash_busy) busy_seen = busy_seen + 1;
            @(negedge clk);
        end
        if (exp_given >= 0) check({tag, " directed status"}, int'(rsp_status), exp_given);
        check({tag, " status"}, int'(rsp_status), est);
        check({tag, " R9 words"}, int'(rsp_words), ewords);
        check({tag, " R13 engine starts"}, start_cnt - s0, eng ? 1 : 0);
        check({tag, " R13 busy seen"}, int'(busy_seen > 0), eng ? 1 : 0);
        @(negedge clk);
        check({tag, " R12 response held"}, int'(rsp_valid && !cmd_ready), 1);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        cfg_busy  = 1'b0;
        if (est == 0) begin
            if (op == 0) begin m_owned = 1; m_owner = cl; m_sel = 0; end
            else if (op == 1) begin m_owned = 0; m_sel = 0; m_cs = 15; end
            else if (op == 2) begin m_sel = 1; m_cs = 15 & ~(1 << arg); end
        end
        check({tag, " R5 R10 R11 chip selects"}, int'(flash_cs_n), m_cs);
    endtask

    function automatic int pick_arg(int i);
        case (i)
            0: return 0;   1: return 1;   2: return 2;    3: return 3;
            4: return 4;   5: return 5;   6: return 8;    7: return 9;
            8: return 32;  9: return 64;  10: return 1024; 11: return 1025;
            default: return 16;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12 reset ready", int'(cmd_ready), 1);
        check("R12 reset no response", int'(rsp_valid), 0);
        check("R10 reset chip selects high", int'(flash_cs_n), 15);
        check("R13 reset engine idle", int'(flash_busy), 0);

        do_cmd("R2 open while configuring", 1, 0, 0, 1, 4);
        do_cmd("R2 open granted", 1, 0, 0, 0, 0);
        do_cmd("R2 open by other while owned", 2, 0, 0, 0, 1);
        do_cmd("R2 reopen by owner", 1, 0, 0, 0, 1);
        do_cmd("R3 read by non-owner", 2, 3, 4, 0, 1);
        do_cmd("R4 read before select", 1, 3, 4, 0, 2);
        do_cmd("R4 sequence before config", 1, 3, 4, 1, 2);
        do_cmd("R5 select out of range", 1, 2, 5, 0, 3);
        do_cmd("R5 select line 2", 1, 2, 2, 0, 0);
        check("R5 line 2 low", int'(flash_cs_n), 4'b1011);
        do_cmd("R6 read max length", 1, 3, 1024, 0, 0);
        do_cmd("R6 write over limit", 1, 4, 1025, 0, 3);
        do_cmd("R6 read zero length", 1, 3, 0, 0, 3);
        do_cmd("R7 read while configuring", 1, 3, 8, 1, 4);
        do_cmd("R7 config before length", 1, 4, 5000, 1, 4);
        do_cmd("R8 erase 32", 1, 5, 32, 0, 0);
        do_cmd("R8 erase 16", 1, 5, 16, 0, 3);
        do_cmd("R9 register read 5 bytes", 1, 6, 5, 0, 0);
        check("R9 padded to two words", int'(rsp_words), 2);
        do_cmd("R9 register write 9 bytes", 1, 7, 9, 0, 3);
        do_cmd("R11 close by non-owner", 3, 1, 0, 0, 1);
        check("R11 selection kept", int'(flash_cs_n), 4'b1011);
        do_cmd("R10 close by owner", 1, 1, 0, 0, 0);
        do_cmd("R3 command with no owner", 1, 2, 0, 0, 1);
        do_cmd("R4 reopen needs select", 0, 0, 0, 0, 0);
        do_cmd("R4 data before new select", 0, 5, 4, 0, 2);
        do_cmd("R1 close", 0, 1, 0, 0, 0);

        // near-exhaustive sweep of client, operation, argument and config level
        for (int n = 0; n < 2500; n++) begin
            int cl, op, ai;
            bit cf;
            cl = ($urandom_range(0, 1) == 0 && m_owned) ? m_owner : int'($urandom_range(0, 3));
            op = int'($urandom_range(0, 7));
            ai = int'($urandom_range(0, 12));
            cf = ($urandom_range(0, 5) == 0);
            do_cmd("R1 sweep", cl, op, pick_arg(ai), cf, -1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule